// File: doc/BRIEF.md
# Memory Request Queue Scheduler

This block sits in front of a memory channel and holds up to `DEPTH` pending read and write requests. Each request enters on a valid/ready port with an agent number, a direction flag and a tag. The scheduler then chooses one queued entry per cycle to present on a grant port, and the entry leaves when the grant is taken. Entries are kept packed in arrival order, with slot 0 the oldest. Removing an entry shifts the younger ones down, and a new arrival goes to the first free slot.

Selection follows a fixed priority, and two small state machines hold the history it depends on.

The direction machine has two states, `DIR_READ` and `DIR_WRITE`. It moves `DIR_READ -> DIR_WRITE` when a write is granted and `DIR_WRITE -> DIR_READ` when a read is granted. While it is in `DIR_WRITE`, writes keep the bus until the burst cap is reached, which saves direction turnarounds.

The admission machine has two states, `ADM_OPEN` and `ADM_BLOCKED`. It moves `ADM_OPEN -> ADM_BLOCKED` when occupancy reaches the start threshold and `ADM_BLOCKED -> ADM_OPEN` once occupancy has fallen to the stop threshold. While blocking is in effect, only the privileged agent may enqueue.

The scheduler also has a strict arrival-order mode that switches every reordering rule off. All configuration inputs are static levels that are read every cycle.

Top module: `mrq_sched`

## Requirements
- R1: A synchronous active-high reset empties the queue, clears every pass count and the write-run count, and puts both state machines in their first state (`DIR_READ`, `ADM_OPEN`). After reset `gnt_valid` is 0 and `req_ready` is 1.
- R2: `gnt_valid` is 1 exactly when the queue holds at least one entry. `req_ready` is 0 whenever the queue holds `DEPTH` entries. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1.
- R3: When `cfg_in_order` is 1, the grant port always shows the oldest queued entry, so entries leave in the order they were accepted.
- R4: Each queued read counts how many younger reads were granted before it, saturating at 15. A read whose count is at least `cfg_age_limit` is forced out first, the oldest such read taking precedence. As a result, no read's count exceeds `cfg_age_limit`.
- R5: Writes are chosen ahead of pending reads only in `DIR_WRITE`, and only while the run of writes granted with reads waiting is below `cfg_wr_cap`. That run count is cleared by a read grant and by any cycle in which no read is queued.
- R6: When neither R3 nor R4 decides, the scheduler picks as follows. In `DIR_WRITE`, within the cap of R5, it takes the oldest write. Otherwise it takes the oldest read from agent `PRIV_AGENT`, then the oldest read from any agent, then the oldest write.
- R7: In `ADM_OPEN`, blocking starts as soon as occupancy is at least `cfg_blk_start`. While blocking is in effect, `req_ready` is 0 for every agent other than `PRIV_AGENT`.
- R8: In `ADM_BLOCKED`, blocking remains while occupancy is above `cfg_blk_stop`, even below `cfg_blk_start`. The privileged agent is admitted whenever the queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_age_limit | input | 4 | Younger-read pass count that forces a read out |
| cfg_wr_cap | input | 4 | Longest write run while reads wait |
| cfg_blk_start | input | 4 | Occupancy that starts blocking other agents |
| cfg_blk_stop | input | 4 | Occupancy at or below which blocking ends |
| cfg_in_order | input | 1 | Strict arrival-order issue |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_agent | input | AGW | Requesting agent number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tag | input | TAGW | Request tag |
| gnt_valid | output | 1 | A queued entry is offered |
| gnt_ready | input | 1 | Channel takes the offered entry |
| gnt_agent | output | AGW | Agent of the offered entry |
| gnt_write | output | 1 | Direction of the offered entry |
| gnt_tag | output | TAGW | Tag of the offered entry |

## Verification
The bench builds the block with `DEPTH` = 16, `AGW` = 2, `TAGW` = 8 and `PRIV_AGENT` = 0. A 16-entry queue fills within a few cycles once the grant side stalls, so the full-queue edge and both admission thresholds (start 10, stop 6) come up again and again. With four agents, the privileged agent's reads overtake other agents' reads often. With age limit 2 and write cap 2, the forced-read and burst-cap paths are taken many times per run. The default values, 8 and 5, are also run.

// File: rtl/mrq_pkg.sv
package mrq_pkg;
    // width of every configuration field and of the per-entry counters
    localparam int CFG_W = 4;

    typedef enum logic [0:0] {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } dir_state_t;

    typedef enum logic [0:0] {
        ADM_OPEN    = 1'b0,
        ADM_BLOCKED = 1'b1
    } adm_state_t;
endpackage

// File: rtl/mrq_admit.sv
module mrq_admit
    import mrq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    occ,
    input  logic [CFG_W-1:0] thr_start,
    input  logic [CFG_W-1:0] thr_stop,
    output logic             blocking
);
    adm_state_t state_q, state_d;
    logic [CW-1:0] start_w, stop_w;

    assign start_w = CW'(thr_start);
    assign stop_w  = CW'(thr_stop);

    always_ff @(posedge clk) begin
        if (rst) state_q <= ADM_OPEN;
        else     state_q <= state_d;
    end

    always_comb begin
        blocking = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            ADM_OPEN: begin
                blocking = (occ >= start_w);
                if (blocking) state_d = ADM_BLOCKED;
            end
            ADM_BLOCKED: begin
                blocking = (occ > stop_w);
                if (!blocking) state_d = ADM_OPEN;
            end
            default: state_d = ADM_OPEN;
        endcase
    end
endmodule

// File: rtl/mrq_pick.sv
module mrq_pick
    import mrq_pkg::*;
#(
    parameter int          DEPTH      = 16,
    parameter int          AGW        = 2,
    parameter int unsigned PRIV_AGENT = 0,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]            vld,
    input  logic [DEPTH-1:0]            wr,
    input  logic [DEPTH-1:0][AGW-1:0]   agent,
    input  logic [DEPTH-1:0][CFG_W-1:0] pcnt,
    input  logic [CFG_W-1:0]            age_limit,
    input  logic [CFG_W-1:0]            wr_cap,
    input  logic [CFG_W-1:0]            wr_run,
    input  logic                        in_order,
    input  logic                        in_wr_burst,
    output logic [IW-1:0]               sel,
    output logic                        rd_pending
);
    logic          f_rd, f_wr, f_forced, f_priv;
    logic [IW-1:0] i_rd, i_wr, i_forced, i_priv;

    // scan from youngest to oldest so the oldest match is kept last
    always_comb begin
        f_rd = 1'b0; f_wr = 1'b0; f_forced = 1'b0; f_priv = 1'b0;
        i_rd = '0;   i_wr = '0;   i_forced = '0;   i_priv = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld[i] && !wr[i]) begin
                f_rd = 1'b1;
                i_rd = IW'(i);
                if (pcnt[i] >= age_limit) begin
                    f_forced = 1'b1;
                    i_forced = IW'(i);
                end
                if (agent[i] == AGW'(PRIV_AGENT)) begin
                    f_priv = 1'b1;
                    i_priv = IW'(i);
                end
            end
            if (vld[i] && wr[i]) begin
                f_wr = 1'b1;
                i_wr = IW'(i);
            end
        end
    end

    assign rd_pending = f_rd;

    always_comb begin
        if (in_order)                                     sel = '0;
        else if (f_forced)                                sel = i_forced;
        else if (in_wr_burst && f_wr && (!f_rd || wr_run < wr_cap)) sel = i_wr;
        else if (f_priv)                                  sel = i_priv;
        else if (f_rd)                                    sel = i_rd;
        else                                              sel = i_wr;
    end
endmodule

// File: rtl/mrq_sched.sv
module mrq_sched
    import mrq_pkg::*;
#(
    parameter int          DEPTH      = 16,
    parameter int          AGW        = 2,
    parameter int          TAGW       = 8,
    parameter int unsigned PRIV_AGENT = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CFG_W-1:0] cfg_age_limit,
    input  logic [CFG_W-1:0] cfg_wr_cap,
    input  logic [CFG_W-1:0] cfg_blk_start,
    input  logic [CFG_W-1:0] cfg_blk_stop,
    input  logic             cfg_in_order,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AGW-1:0]   req_agent,
    input  logic             req_write,
    input  logic [TAGW-1:0]  req_tag,
    output logic             gnt_valid,
    input  logic             gnt_ready,
    output logic [AGW-1:0]   gnt_agent,
    output logic             gnt_write,
    output logic [TAGW-1:0]  gnt_tag
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CFG_W-1:0] CNT_MAX = '1;

    // packed queue storage, slot 0 oldest
    logic [DEPTH-1:0]             e_vld, n_vld;
    logic [DEPTH-1:0]             e_wr,  n_wr;
    logic [DEPTH-1:0][AGW-1:0]    e_ag,  n_ag;
    logic [DEPTH-1:0][TAGW-1:0]   e_tag, n_tag;
    logic [DEPTH-1:0][CFG_W-1:0]  e_pc,  n_pc, pc_bump;
    logic [CW-1:0]                count, n_count, wpos;
    logic [CFG_W-1:0]             run, n_run;
    logic [IW-1:0]                sel;
    logic                         rd_pending, blocking, issue, accept;
    dir_state_t                   dir_q, dir_d;

    mrq_pick #(
        .DEPTH(DEPTH), .AGW(AGW), .PRIV_AGENT(PRIV_AGENT)
    ) u_pick (
        .vld(e_vld), .wr(e_wr), .agent(e_ag), .pcnt(e_pc),
        .age_limit(cfg_age_limit), .wr_cap(cfg_wr_cap), .wr_run(run),
        .in_order(cfg_in_order), .in_wr_burst(dir_q == DIR_WRITE),
        .sel(sel), .rd_pending(rd_pending)
    );

    mrq_admit #(.DEPTH(DEPTH)) u_admit (
        .clk(clk), .rst(rst), .occ(count),
        .thr_start(cfg_blk_start), .thr_stop(cfg_blk_stop),
        .blocking(blocking)
    );

    // output process: grant and admission ports
    always_comb begin
        gnt_valid = e_vld[0];
        gnt_agent = e_ag[sel];
        gnt_write = e_wr[sel];
        gnt_tag   = e_tag[sel];
        req_ready = (count < CW'(DEPTH)) &&
                    (!blocking || req_agent == AGW'(PRIV_AGENT));
    end

    assign issue  = gnt_valid && gnt_ready;
    assign accept = req_valid && req_ready;
    assign wpos   = count - CW'(issue);

    // direction state machine
    always_ff @(posedge clk) begin
        if (rst) dir_q <= DIR_READ;
        else     dir_q <= dir_d;
    end

    always_comb begin
        dir_d = dir_q;
        unique case (dir_q)
            DIR_READ:  if (issue && gnt_write)  dir_d = DIR_WRITE;
            DIR_WRITE: if (issue && !gnt_write) dir_d = DIR_READ;
            default:   dir_d = DIR_READ;
        endcase
    end

    // write-run counter
    always_comb begin
        n_run = run;
        if (issue) begin
            if (gnt_write && rd_pending) n_run = (run == CNT_MAX) ? run : run + 1'b1;
            else                         n_run = '0;
        end else if (!rd_pending) begin
            n_run = '0;
        end
    end

    // pass counts of older reads grow when a younger read leaves
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            pc_bump[i] = e_pc[i];
            if (issue && !gnt_write && i < int'(sel) && e_vld[i] && !e_wr[i] &&
                e_pc[i] != CNT_MAX)
                pc_bump[i] = e_pc[i] + 1'b1;
        end
    end

    // remove the granted slot, compact, then append the arrival
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (issue && i >= int'(sel)) begin
                if (i + 1 < DEPTH) begin
                    n_vld[i] = e_vld[i+1];
                    n_wr[i]  = e_wr[i+1];
                    n_ag[i]  = e_ag[i+1];
                    n_tag[i] = e_tag[i+1];
                    n_pc[i]  = pc_bump[i+1];
                end else begin
                    n_vld[i] = 1'b0;
                    n_wr[i]  = 1'b0;
                    n_ag[i]  = '0;
                    n_tag[i] = '0;
                    n_pc[i]  = '0;
                end
            end else begin
                n_vld[i] = e_vld[i];
                n_wr[i]  = e_wr[i];
                n_ag[i]  = e_ag[i];
                n_tag[i] = e_tag[i];
                n_pc[i]  = pc_bump[i];
            end
            if (accept && i == int'(wpos)) begin
                n_vld[i] = 1'b1;
                n_wr[i]  = req_write;
                n_ag[i]  = req_agent;
                n_tag[i] = req_tag;
                n_pc[i]  = '0;
            end
        end
        n_count = count + CW'(accept) - CW'(issue);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_vld <= '0;
            e_wr  <= '0;
            e_ag  <= '0;
            e_tag <= '0;
            e_pc  <= '0;
            count <= '0;
            run   <= '0;
        end else begin
            e_vld <= n_vld;
            e_wr  <= n_wr;
            e_ag  <= n_ag;
            e_tag <= n_tag;
            e_pc  <= n_pc;
            count <= n_count;
            run   <= n_run;
        end
    end
endmodule

// File: rtl/mrq_sched_chk.sv
module mrq_sched_chk
    import mrq_pkg::*;
#(
    parameter int          DEPTH      = 16,
    parameter int          AGW        = 2,
    parameter int unsigned PRIV_AGENT = 0,
    localparam int IW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_ready,
    input logic [AGW-1:0]              req_agent,
    input logic                        gnt_valid,
    input logic                        gnt_write,
    input logic                        cfg_in_order,
    input logic [CFG_W-1:0]            cfg_age_limit,
    input logic [CFG_W-1:0]            cfg_wr_cap,
    input logic [CFG_W-1:0]            cfg_blk_start,
    input logic [CFG_W-1:0]            cfg_blk_stop,
    input logic [CW-1:0]               count,
    input logic [IW-1:0]               sel,
    input logic [CFG_W-1:0]            run,
    input logic                        rd_pending,
    input logic                        blocking,
    input logic [DEPTH-1:0]            e_vld,
    input logic [DEPTH-1:0]            e_wr,
    input logic [DEPTH-1:0][CFG_W-1:0] e_pc
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (count == '0 && !gnt_valid));

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_full_stall_R2: assert property (@(posedge clk) disable iff (rst)
        (count == CW'(DEPTH)) |-> !req_ready);

    assert_head_only_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_in_order && gnt_valid) |-> (sel == '0));

    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        assert_age_force_R4: assert property (@(posedge clk) disable iff (rst)
            (gnt_valid && !cfg_in_order && g < int'(sel)) |->
            !(e_vld[g] && !e_wr[g] && e_pc[g] >= cfg_age_limit));
    end

    assert_wr_cap_R5: assert property (@(posedge clk) disable iff (rst)
        (gnt_valid && gnt_write && rd_pending && !cfg_in_order) |-> (run < cfg_wr_cap));

    assert_block_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(blocking) |-> (count >= CW'(cfg_blk_start)));

    assert_blocked_agent_R7: assert property (@(posedge clk) disable iff (rst)
        (blocking && req_agent != AGW'(PRIV_AGENT)) |-> !req_ready);

    assert_block_stop_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(blocking) |-> (count <= CW'(cfg_blk_stop)));
endmodule

bind mrq_sched mrq_sched_chk #(
    .DEPTH(DEPTH), .AGW(AGW), .PRIV_AGENT(PRIV_AGENT)
) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .req_agent(req_agent),
    .gnt_valid(gnt_valid), .gnt_write(gnt_write), .cfg_in_order(cfg_in_order),
    .cfg_age_limit(cfg_age_limit), .cfg_wr_cap(cfg_wr_cap),
    .cfg_blk_start(cfg_blk_start), .cfg_blk_stop(cfg_blk_stop),
    .count(count), .sel(sel), .run(run), .rd_pending(rd_pending),
    .blocking(blocking), .e_vld(e_vld), .e_wr(e_wr), .e_pc(e_pc)
);

// File: tb/mrq_sched_test.sv
module mrq_sched_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cfg_age_limit = 4'd8, cfg_wr_cap = 4'd5;
    logic [3:0] cfg_blk_start = 4'd10, cfg_blk_stop = 4'd6;
    logic       cfg_in_order = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, gnt_ready = 1'b0;
    logic [1:0] req_agent = '0;
    logic [7:0] req_tag = '0;
    logic       req_ready, gnt_valid, gnt_write;
    logic [1:0] gnt_agent;
    logic [7:0] gnt_tag;

    int tests = 0, fails = 0, next_tag = 0;

    // reference model: arrival-ordered lists
    bit qw[$];
    int qa[$], qt[$], qp[$];
    bit m_wrdir = 0, m_blk = 0;
    int m_run = 0;

    mrq_sched #(.DEPTH(16), .AGW(2), .TAGW(8), .PRIV_AGENT(0)) uut (
        .clk(clk), .rst(rst), .cfg_age_limit(cfg_age_limit), .cfg_wr_cap(cfg_wr_cap),
        .cfg_blk_start(cfg_blk_start), .cfg_blk_stop(cfg_blk_stop),
        .cfg_in_order(cfg_in_order), .req_valid(req_valid), .req_ready(req_ready),
        .req_agent(req_agent), .req_write(req_write), .req_tag(req_tag),
        .gnt_valid(gnt_valid), .gnt_ready(gnt_ready), .gnt_agent(gnt_agent),
        .gnt_write(gnt_write), .gnt_tag(gnt_tag)
    );

    always #5 clk = ~clk;

    task automatic chk(string rq, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic int pick(output string why);
        int fr = -1, fw = -1, fp = -1, ff = -1;
        why = "R6";
        if (qt.size() == 0) return -1;
        if (cfg_in_order) begin why = "R3"; return 0; end
        for (int i = 0; i < qt.size(); i++) begin
            if (!qw[i]) begin
                if (fr < 0) fr = i;
                if (ff < 0 && qp[i] >= int'(cfg_age_limit)) ff = i;
                if (fp < 0 && qa[i] == 0) fp = i;
            end else if (fw < 0) fw = i;
        end
        if (ff >= 0) begin why = "R4"; return ff; end
        if (m_wrdir && fw >= 0 && (fr < 0 || m_run < int'(cfg_wr_cap))) return fw;
        if (m_wrdir && fw >= 0) why = "R5";
        if (fp >= 0) return fp;
        if (fr >= 0) return fr;
        return fw;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; gnt_ready = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        qw.delete(); qa.delete(); qt.delete(); qp.delete();
        m_wrdir = 0; m_blk = 0; m_run = 0;
        #1;
        chk("R1", "gnt_valid after reset", int'(gnt_valid), 0);
        chk("R1", "req_ready after reset", int'(req_ready), 1);
    endtask

    task automatic step(bit v, int ag, bit w, bit gr);
        int  n, s, k, exp_rdy;
        bit  rp, blk, wi;
        string why;
        @(negedge clk);
        req_valid = v; req_agent = 2'(ag); req_write = w;
        req_tag = 8'(next_tag); gnt_ready = gr;
        #1;
        n  = qt.size();
        rp = 0;
        foreach (qw[i]) if (!qw[i]) rp = 1;
        blk = m_blk ? (n > int'(cfg_blk_stop)) : (n >= int'(cfg_blk_start));
        exp_rdy = (n < 16 && (!blk || ag == 0)) ? 1 : 0;
        chk(blk ? (m_blk ? "R8" : "R7") : "R2", "req_ready", int'(req_ready), exp_rdy);
        chk("R2", "gnt_valid", int'(gnt_valid), n > 0 ? 1 : 0);
        if (n > 0) begin
            s = pick(why);
            chk(why, "gnt_tag", int'(gnt_tag), qt[s]);
            chk(why, "gnt_write", int'(gnt_write), int'(qw[s]));
            chk(why, "gnt_agent", int'(gnt_agent), qa[s]);
        end
        // follow the design's actual grant
        if (gnt_valid && gr) begin
            k = -1;
            foreach (qt[i]) if (qt[i] == int'(gnt_tag)) k = i;
            if (k < 0) begin
                chk("R2", "granted tag present", 0, 1);
            end else begin
                wi = qw[k];
                if (!wi) begin
                    bit over = 0;
                    for (int j = 0; j < k; j++)
                        if (!qw[j]) begin
                            if (qp[j] < 15) qp[j]++;
                            if (qp[j] > int'(cfg_age_limit)) over = 1;
                        end
                    chk("R4", "pass count within limit", int'(over), 0);
                end
                if (wi && rp) m_run = (m_run < 15) ? m_run + 1 : 15;
                else          m_run = 0;
                if (wi && rp && !cfg_in_order)
                    chk("R5", "write run within cap", (m_run <= int'(cfg_wr_cap)) ? 1 : 0, 1);
                m_wrdir = wi;
                qw.delete(k); qa.delete(k); qt.delete(k); qp.delete(k);
            end
        end else if (!rp) begin
            m_run = 0;
        end
        m_blk = blk;
        if (v && req_ready) begin
            qw.push_back(w); qa.push_back(ag); qt.push_back(next_tag & 255); qp.push_back(0);
            next_tag = (next_tag + 1) & 255;
        end
    endtask

    task automatic run_rand(int cycles, int vpct, int wpct, int ppct, int gpct);
        for (int c = 0; c < cycles; c++) begin
            int ag = ($urandom_range(99) < ppct) ? 0 : int'($urandom_range(3, 1));
            step($urandom_range(99) < vpct, ag, $urandom_range(99) < wpct,
                 $urandom_range(99) < gpct);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // default limits, mixed traffic (R2, R4, R5, R6, R7, R8)
        do_reset();
        run_rand(3000, 60, 50, 30, 50);

        // tight limits push forced reads and capped bursts (R4, R5)
        cfg_age_limit = 4'd2; cfg_wr_cap = 4'd2;
        do_reset();
        run_rand(3000, 70, 50, 45, 45);

        // strict arrival order (R3)
        cfg_in_order = 1'b1;
        do_reset();
        run_rand(2000, 60, 50, 40, 50);
        cfg_in_order = 1'b0;

        // admission hysteresis, start 10 stop 6
        cfg_age_limit = 4'd8; cfg_wr_cap = 4'd5;
        do_reset();
        for (int i = 0; i < 12; i++) step(1, 1, 0, 0);
        chk("R7", "agent 1 held at start threshold", int'(req_ready), 0);
        for (int i = 0; i < 8; i++) step(1, 0, 1, 0);
        chk("R2", "privileged agent held when full", int'(req_ready), 0);
        for (int i = 0; i < 9; i++) step(1, 1, 0, 1);
        step(1, 1, 0, 1);
        chk("R8", "agent 1 still held between thresholds", int'(req_ready), 0);
        step(1, 1, 0, 1);
        chk("R8", "agent 1 admitted at stop threshold", int'(req_ready), 1);
        for (int i = 0; i < 30; i++) step(0, 1, 0, 1);
        chk("R2", "queue drained", int'(gnt_valid), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule